// File: doc/BRIEF.md
# Periodic Tick Timer

A memory-mapped down-counter that produces a regular time base. Software loads a reload value, selects whether the count advances on every core clock or only on cycles where a slower reference tick enable is high, and starts the count. Each time the count runs out, a sticky status flag is set and, if enabled, a one-cycle interrupt pulse is raised. The count then restarts from the reload value. A reload value of zero gives a single expiry, after which counting stops.

The block is reached through a single-cycle word register bus. Read data and the error response are combinational within the access cycle, and all side effects take place at the clock edge that ends that cycle. Each access carries an unprivileged attribute, and such accesses are refused with an error. Non-word accesses are refused in the same way. Stopping the count keeps the remaining value, so the count can be resumed later from where it stopped.

Top module: `tick_timer`

## Requirements
- R1: After reset the control bits, the count flag, the reload register and the count are all zero, and `irq_pulse` is low.
- R2: Registers sit at byte offsets 0x0 (control), 0x4 (reload), 0x8 (current count) and 0xC (calibration). An access whose `bus_size` is not 2 (word) returns `bus_err`=1 and has no effect. A word access to any other offset reads as zero, ignores write data and does not raise `bus_err`.
- R3: A control write updates only the three low bits: bit 0 starts or stops counting, bit 1 enables the interrupt, and bit 2 selects the clock source (1 = every core clock, 0 = only when `ref_tick_en` is high). The count flag is kept.
- R4: A control read returns the count flag in bit 16 and the control bits in bits 2:0, and it clears the flag. If an expiry happens in the same cycle as that read, the read returns the old flag value and the flag ends up set.
- R5: While counting, the count steps down by one per tick. An expiry happens on the tick that finds the count at zero, and that tick reloads the count. Successive expiries are therefore reload+1 ticks apart, and the first expiry comes reload+1 ticks after a start that loaded the count.
- R6: An expiry sets the count flag. If bit 1 is set, `irq_pulse` is high for exactly the one cycle after the expiry edge.
- R7: When an expiry happens with a reload value of zero, bit 0 is cleared and counting stops.
- R8: Any write to the current-count register, whatever its data, loads the count from the reload value and clears the count flag. That cycle's tick is dropped.
- R9: Clearing bit 0 freezes the remaining count, and the stopping edge does not count as a tick. Setting bit 0 again resumes from that count if it is nonzero. Otherwise it loads the count from the reload value.
- R10: While bit 0 is clear, the current-count register reads zero.
- R11: A control write that changes bit 2 while counting stays enabled loads the count from the reload value.
- R12: The calibration register always reads 10000 and ignores writes.
- R13: An access with `bus_unpriv`=1 returns `bus_err`=1 and read data zero. It changes no register, and it does not clear the flag.
- R14: The reload register holds CNT_W (24) bits. Its upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_en | input | 1 | Reference tick enable, counted when bit 2 is clear |
| bus_sel | input | 1 | Access valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset |
| bus_size | input | 2 | Access size code, 2 = word |
| bus_unpriv | input | 1 | Unprivileged access attribute |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Error response, valid in the access cycle |
| irq_pulse | output | 1 | One-cycle expiry interrupt |

## Verification
Read data and `bus_err` are due in the same cycle as the access. The bench drives each access just after a falling edge and samples the response one time unit later, before the rising edge that carries out the access's side effects. A count loaded at edge E0 reads reload−k after edge Ek. The expiry falls on edge E(reload+1), the flag is visible to the very next access, and `irq_pulse` is high only between E(reload+1) and E(reload+2). Every access task takes exactly one rising edge and idle waits are counted in edges, so each check samples at the falling edge that follows the edge where the result first appears.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned FLAG_POS = 16;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_RLD   = 8'h04;
    localparam logic [7:0] OFS_CUR   = 8'h08;
    localparam logic [7:0] OFS_CAL   = 8'h0C;

    // bit 0 = run_en, bit 1 = int_en, bit 2 = src_core
    typedef struct packed {
        logic src_core;
        logic int_en;
        logic run_en;
    } ctrl_t;

    typedef struct packed {
        logic ctrl;
        logic rld;
        logic cur;
        logic cal;
    } reg_hit_t;

endpackage

// File: rtl/tick_bus_decode.sv
module tick_bus_decode
    import tick_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              unpriv,
    output logic              acc_err,
    output reg_hit_t          rd_hit,
    output reg_hit_t          wr_hit
);

    logic     acc_ok;
    reg_hit_t hit;

    always_comb begin
        acc_ok   = sel & ~unpriv & (size == SIZE_WORD);
        acc_err  = sel & ~acc_ok;
        hit.ctrl = (addr == ADDR_W'(OFS_CTRL));
        hit.rld  = (addr == ADDR_W'(OFS_RLD));
        hit.cur  = (addr == ADDR_W'(OFS_CUR));
        hit.cal  = (addr == ADDR_W'(OFS_CAL));
        rd_hit   = (acc_ok & ~write) ? hit : '0;
        wr_hit   = (acc_ok &  write) ? hit : '0;
    end

    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_hit, wr_hit}));

    // R13
    err_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (rd_hit == '0 && wr_hit == '0));

endmodule

// File: rtl/tick_count_core.sv
module tick_count_core #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] rld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     advance;
    logic     at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.cnt == '0);
        advance = run & step & ~load;
        expire  = advance & at_zero;
        if (load) begin
            st_d.cnt = rld_val;
        end else if (advance) begin
            st_d.cnt = at_zero ? rld_val : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R9
    frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(st_q.cnt));

    // R8
    load_takes_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.cnt == $past(rld_val)));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 24,
    parameter int unsigned CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_en,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_unpriv,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              irq_pulse
);

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             flag;
        logic [CNT_W-1:0] rld;
        logic             irq;
    } top_st_t;

    top_st_t          st_d, st_q;
    reg_hit_t         rd_hit, wr_hit;
    ctrl_t            wr_ctrl;
    logic             en_keep, en_rise, src_flip;
    logic             load_cnt, step;
    logic [CNT_W-1:0] cnt;
    logic             expire;

    tick_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .write   (bus_write),
        .addr    (bus_addr),
        .size    (bus_size),
        .unpriv  (bus_unpriv),
        .acc_err (bus_err),
        .rd_hit  (rd_hit),
        .wr_hit  (wr_hit)
    );

    tick_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (en_keep),
        .step    (step),
        .load    (load_cnt),
        .rld_val (st_q.rld),
        .cnt     (cnt),
        .expire  (expire)
    );

    // control-write side effects on the counter
    always_comb begin
        wr_ctrl  = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        en_keep  = st_q.ctrl.run_en & ~(wr_hit.ctrl & ~wr_ctrl.run_en);
        en_rise  = wr_hit.ctrl & wr_ctrl.run_en & ~st_q.ctrl.run_en;
        src_flip = wr_hit.ctrl & st_q.ctrl.run_en & wr_ctrl.run_en
                 & (wr_ctrl.src_core != st_q.ctrl.src_core);
        load_cnt = wr_hit.cur | src_flip | (en_rise & (cnt == '0));
        step     = st_q.ctrl.src_core | ref_tick_en;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (wr_hit.ctrl) st_d.ctrl = wr_ctrl;
        if (wr_hit.rld)  st_d.rld  = bus_wdata[CNT_W-1:0];
        if (rd_hit.ctrl || wr_hit.cur) st_d.flag = 1'b0;
        if (expire) begin
            st_d.flag = 1'b1;
            if (st_q.rld == '0) st_d.ctrl.run_en = 1'b0;
        end
        st_d.irq = expire & st_q.ctrl.int_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (rd_hit.ctrl) begin
            bus_rdata[FLAG_POS]   = st_q.flag;
            bus_rdata[CTRL_W-1:0] = st_q.ctrl;
        end else if (rd_hit.rld) begin
            bus_rdata[CNT_W-1:0] = st_q.rld;
        end else if (rd_hit.cur) begin
            bus_rdata[CNT_W-1:0] = st_q.ctrl.run_en ? cnt : '0;
        end else if (rd_hit.cal) begin
            bus_rdata = DATA_W'(CAL_VALUE);
        end
    end

    assign irq_pulse = st_q.irq;

    // R6
    irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> st_q.flag);

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && st_q.rld == '0) |=> !st_q.ctrl.run_en);

    // R13
    err_keeps_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> $stable(st_q.rld));

    // R13
    err_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && st_q.flag) |=> st_q.flag);

    // R13
    err_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !expire) |=> $stable(st_q.ctrl));

endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic        bus_unpriv = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tick_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_tick_en (ref_tick_en),
        .bus_sel     (bus_sel),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_size    (bus_size),
        .bus_unpriv  (bus_unpriv),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_err     (bus_err),
        .irq_pulse   (irq_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; takes exactly one rising edge.
    task automatic access(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                          input logic unpriv, input logic [1:0] size,
                          output logic [31:0] rd, output logic err);
        bus_sel    = 1'b1;
        bus_write  = wr;
        bus_addr   = addr;
        bus_wdata  = wd;
        bus_unpriv = unpriv;
        bus_size   = size;
        #1;
        rd  = bus_rdata;
        err = bus_err;
        @(negedge clk);
        bus_sel    = 1'b0;
        bus_unpriv = 1'b0;
        bus_size   = 2'd2;
    endtask

    task automatic wr32(input logic [7:0] addr, input logic [31:0] wd);
        logic [31:0] rd;
        logic        err;
        access(1'b1, addr, wd, 1'b0, 2'd2, rd, err);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] addr, input logic [31:0] exp);
        logic [31:0] rd;
        logic        err;
        access(1'b0, addr, '0, 1'b0, 2'd2, rd, err);
        check(req, rd, exp);
        check(req, {31'b0, err}, 32'd0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ref_pulse();
        ref_tick_en = 1'b1;
        @(negedge clk);
        ref_tick_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 irq", {31'b0, irq_pulse}, 32'd0);
        rd_chk("R1 ctrl", 8'h00, 32'd0);
        rd_chk("R1 reload", 8'h04, 32'd0);
        rd_chk("R1 count", 8'h08, 32'd0);
    endtask

    task automatic t_map();
        logic [31:0] rd;
        logic        err;
        wr32(8'h0C, 32'd5);
        rd_chk("R12 calibration", 8'h0C, 32'd10000);
        rd_chk("R2 undefined read", 8'h10, 32'd0);
        access(1'b1, 8'h14, 32'hFFFF_FFFF, 1'b0, 2'd2, rd, err);
        check("R2 undefined write err", {31'b0, err}, 32'd0);
        rd_chk("R2 reload untouched", 8'h04, 32'd0);
        rd_chk("R2 ctrl untouched", 8'h00, 32'd0);
        access(1'b0, 8'h0C, '0, 1'b0, 2'd1, rd, err);
        check("R2 half access err", {31'b0, err}, 32'd1);
        access(1'b1, 8'h04, 32'd7, 1'b0, 2'd0, rd, err);
        check("R2 byte write err", {31'b0, err}, 32'd1);
        rd_chk("R2 byte write ignored", 8'h04, 32'd0);
    endtask

    task automatic t_reload_width();
        wr32(8'h04, 32'hFFFF_FFFF);
        rd_chk("R14 reload width", 8'h04, 32'h00FF_FFFF);
        wr32(8'h04, 32'd4);
    endtask

    task automatic t_periodic_core();
        wr32(8'h00, 32'hFFFF_0005);           // E0: start, core clock
        rd_chk("R5 count after load", 8'h08, 32'd4);
        idle(3);                              // after E4
        rd_chk("R3 ctrl bits only", 8'h00, 32'h5);   // consumes E5 expiry
        check("R6 no irq when bit1 clear", {31'b0, irq_pulse}, 32'd0);
        rd_chk("R6 flag set", 8'h00, 32'h0001_0005);
        rd_chk("R4 flag cleared by read", 8'h00, 32'h5);
        wr32(8'h00, 32'h0);
    endtask

    task automatic t_irq();
        wr32(8'h08, 32'd0);                   // count = 4
        wr32(8'h00, 32'h7);                   // E0
        idle(4);
        check("R6 irq before expiry", {31'b0, irq_pulse}, 32'd0);
        idle(1);
        check("R6 irq after expiry", {31'b0, irq_pulse}, 32'd1);
        idle(1);
        check("R6 irq one cycle", {31'b0, irq_pulse}, 32'd0);
        idle(3);
        check("R5 no early second expiry", {31'b0, irq_pulse}, 32'd0);
        idle(1);
        check("R5 period reload+1", {31'b0, irq_pulse}, 32'd1);
        wr32(8'h00, 32'h0);
    endtask

    task automatic t_ref_source();
        wr32(8'h04, 32'd2);
        wr32(8'h08, 32'd0);
        wr32(8'h00, 32'h3);                   // start, int, reference ticks
        idle(10);
        rd_chk("R5 no ticks without ref", 8'h08, 32'd2);
        ref_pulse();
        ref_pulse();
        rd_chk("R5 ref ticks counted", 8'h08, 32'd0);
        check("R6 no irq yet", {31'b0, irq_pulse}, 32'd0);
        ref_pulse();
        check("R5 ref expiry irq", {31'b0, irq_pulse}, 32'd1);
        wr32(8'h00, 32'h0);
        rd_chk("R4 clear leftover flag", 8'h00, 32'h0001_0000);
    endtask

    task automatic t_oneshot();
        wr32(8'h04, 32'd0);
        wr32(8'h08, 32'd0);
        wr32(8'h00, 32'h5);                   // E0 load 0
        rd_chk("R4 same-edge read sees old flag", 8'h00, 32'h5);
        rd_chk("R7 stopped after one-shot", 8'h00, 32'h0001_0004);
        rd_chk("R10 count reads zero when stopped", 8'h08, 32'd0);
        idle(3);
        rd_chk("R7 stays stopped", 8'h00, 32'h4);
    endtask

    task automatic t_restart();
        wr32(8'h04, 32'd2);
        wr32(8'h08, 32'd0);
        wr32(8'h00, 32'h5);                   // E0, count 2
        idle(5);                              // expiry at E3
        wr32(8'h08, 32'h0000_DEAD);           // E6 restart
        rd_chk("R8 restart value", 8'h08, 32'd2);
        rd_chk("R8 flag cleared", 8'h00, 32'h5);
        wr32(8'h00, 32'h4);
    endtask

    task automatic t_pause_src();
        wr32(8'h04, 32'd20);
        wr32(8'h08, 32'd0);
        wr32(8'h00, 32'h5);                   // E0, count 20
        idle(4);                              // count 16
        wr32(8'h00, 32'h4);                   // stop, no tick
        rd_chk("R10 reads zero while stopped", 8'h08, 32'd0);
        idle(5);
        wr32(8'h00, 32'h5);                   // resume
        rd_chk("R9 resumes remaining count", 8'h08, 32'd16);
        idle(2);                              // count 13
        wr32(8'h00, 32'h1);                   // source change while running
        rd_chk("R11 source change reloads", 8'h08, 32'd20);
        wr32(8'h00, 32'h0);
    endtask

    task automatic t_unpriv();
        logic [31:0] rd;
        logic        err;
        wr32(8'h04, 32'd0);
        wr32(8'h08, 32'd0);
        wr32(8'h00, 32'h5);
        idle(1);                              // one-shot done, flag set
        access(1'b0, 8'h00, '0, 1'b1, 2'd2, rd, err);
        check("R13 read err", {31'b0, err}, 32'd1);
        check("R13 read data zero", rd, 32'd0);
        rd_chk("R13 flag kept", 8'h00, 32'h0001_0004);
        access(1'b1, 8'h04, 32'd55, 1'b1, 2'd2, rd, err);
        check("R13 write err", {31'b0, err}, 32'd1);
        rd_chk("R13 reload kept", 8'h04, 32'd0);
        access(1'b1, 8'h00, 32'h5, 1'b1, 2'd2, rd, err);
        rd_chk("R13 ctrl kept", 8'h00, 32'h4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_reload_width();
        t_periodic_core();
        t_irq();
        t_ref_source();
        t_oneshot();
        t_restart();
        t_pause_src();
        t_unpriv();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule